// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a watchdog counter that advances on a slow reference tick. Software proves it is alive by pulsing a kick, which restarts the count from zero. If no kick comes, the counter first reaches half of its period. There it raises an early-warning interrupt, so software gets a chance to recover. If the count then reaches the full period, the block emits a one-cycle device reset request and starts counting again from zero.

One counter serves both thresholds. The period is a parameter in ticks, and the warning point is exactly half of it. With a 32.768 kHz reference tick, a period of 131072 ticks gives a warning after about two seconds and a reset after about four. The current count can be read back at any time.

Top module: `wdtTwoStage`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the count reads 0 and both irqOut and resetReq are low.
- R2: In a clock cycle with tick high and kick low, the count rises by one. In a cycle with tick low and kick low, the count holds its value.
- R3: A cycle with kick high sets the count to 0 on the next edge, whether or not tick is high.
- R4: The tick that moves the count from PERIOD_TICKS/2-1 to PERIOD_TICKS/2 sets irqOut high on the same edge.
- R5: Once high, irqOut stays high until a cycle with irqClear or kick high. If irqClear falls in the same cycle as the warning tick, irqOut still goes high.
- R6: A tick at count PERIOD_TICKS-1 with kick low drives resetReq high for exactly one cycle. On that same edge the count returns to 0.
- R7: A kick in the same cycle as the final tick wins. No reset request is issued, and the count goes to 0.
- R8: The edge that issues a reset request also drops irqOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse from the slow reference time base |
| kick | input | 1 | Software activity strobe; restarts the count |
| irqClear | input | 1 | Clears the early-warning interrupt |
| irqOut | output | 1 | Early-warning interrupt, level |
| resetReq | output | 1 | One-cycle device reset request |
| countOut | output | CNT_W | Current count, in ticks |

## Verification
The count is exercised in three ways:
- A tick on every cycle gives plain increments.
- Sparse ticks separate advancing from holding.
- Kicks arrive with and without a tick, which shows that a kick dominates.

Runs with no kick carry the count through both thresholds, so the warning edge, the single reset pulse and the wrap to zero are all seen. Further runs pair the final tick with a kick, and the warning tick with an interrupt clear, to pin down the two priority rules. A behavioural model in the bench predicts the count, the interrupt and the reset request, and these are compared on every cycle.

// File: rtl/wdtPkg.sv
package wdtPkg;
  // strobes from control to the counter datapath
  typedef struct packed {
    logic clear;
    logic inc;
  } wdtStrobeT;
endpackage

// File: rtl/wdtDatapath.sv
module wdtDatapath
  import wdtPkg::*;
#(
  parameter int PERIOD_TICKS = 131072,
  parameter int CNT_W = $clog2(PERIOD_TICKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobeT        strobe,
  input  logic             kickIn,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (strobe.clear) count <= '0;
    else if (strobe.inc)   count <= count + 1'b1;
  end

  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(PERIOD_TICKS - 1));
  a_r3_kick_zero: assert property (@(posedge clk) disable iff (!rstN)
    kickIn |=> count == '0);
endmodule

// File: rtl/wdtControl.sv
module wdtControl
  import wdtPkg::*;
#(
  parameter int PERIOD_TICKS = 131072,
  parameter int CNT_W = $clog2(PERIOD_TICKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             kick,
  input  logic             irqClear,
  input  logic [CNT_W-1:0] countIn,
  output wdtStrobeT        strobe,
  output logic             irqQ,
  output logic             resetReqQ
);
  localparam int HALF = PERIOD_TICKS / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);
  localparam logic [CNT_W-1:0] WARN_PRE = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] WARN_AT = CNT_W'(HALF);

  logic atFull, warnHit;

  always_comb begin
    atFull       = tick && !kick && (countIn == LAST);
    warnHit      = tick && !kick && (countIn == WARN_PRE);
    strobe.clear = kick || atFull;
    strobe.inc   = tick && !strobe.clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ      <= 1'b0;
      resetReqQ <= 1'b0;
    end else begin
      resetReqQ <= atFull;
      if (kick || atFull) irqQ <= 1'b0;
      else if (warnHit)   irqQ <= 1'b1;
      else if (irqClear)  irqQ <= 1'b0;
    end
  end

  a_r4_irq_at_half: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> countIn == WARN_AT);
  a_r5_kick_clears_irq: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> !irqQ);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetReqQ |=> !resetReqQ);
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    resetReqQ |-> countIn == '0);
  a_r8_reset_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    resetReqQ |-> !irqQ);
endmodule

// File: rtl/wdtTwoStage.sv
module wdtTwoStage
  import wdtPkg::*;
#(
  parameter int PERIOD_TICKS = 131072,
  localparam int CNT_W = $clog2(PERIOD_TICKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             kick,
  input  logic             irqClear,
  output logic             irqOut,
  output logic             resetReq,
  output logic [CNT_W-1:0] countOut
);
  wdtStrobeT strobe;

  wdtControl #(.PERIOD_TICKS(PERIOD_TICKS), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .kick(kick), .irqClear(irqClear),
    .countIn(countOut), .strobe(strobe), .irqQ(irqOut), .resetReqQ(resetReq)
  );

  wdtDatapath #(.PERIOD_TICKS(PERIOD_TICKS), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .kickIn(kick), .count(countOut)
  );

  // R7: a kick on the final tick never lets a reset request out
  a_r7_kick_beats_reset: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> !resetReq);
endmodule

// File: tb/sim_wdtTwoStage.sv
module sim_wdtTwoStage;
  localparam int P = 16;
  localparam int H = P / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, kick = 1'b0, irqClear = 1'b0;
  logic irqOut, resetReq;
  logic [3:0] countOut;

  int nChecks = 0, nFails = 0, cycles = 0;
  int mCnt = 0, mIrq = 0, mRst = 0;
  string curReq = "R1";

  always #4 clk = ~clk;  // 125 MHz

  wdtTwoStage #(.PERIOD_TICKS(P)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .kick(kick), .irqClear(irqClear),
    .irqOut(irqOut), .resetReq(resetReq), .countOut(countOut)
  );

  task automatic chk(string req, int act, int exp, string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model, updated on every edge
  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mIrq = 0; mRst = 0;
    end else begin
      mRst = 0;
      if (kick) begin
        mCnt = 0; mIrq = 0;
      end else if (tick && mCnt == P - 1) begin
        mCnt = 0; mRst = 1; mIrq = 0;
      end else begin
        if (tick) mCnt = mCnt + 1;
        if (tick && mCnt == H) mIrq = 1;
        else if (irqClear) mIrq = 0;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    chk(curReq, int'(countOut), mCnt, "count vs model");
    chk(curReq, int'(irqOut), mIrq, "irq vs model");
    chk(curReq, int'(resetReq), mRst, "resetReq vs model");
    if (cycles > 20000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  task automatic drive(bit k, bit t, bit c, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      kick = k; tick = t; irqClear = c;
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
    kick = 0; tick = 0; irqClear = 0;
  endtask

  initial begin
    curReq = "R1";
    drive(0, 1, 0, 3);   // stimulus during reset is ignored
    settle();
    chk("R1", int'(countOut), 0, "count in reset");
    chk("R1", int'(irqOut), 0, "irq in reset");
    rstN = 1'b1;
    settle();
    chk("R1", int'(resetReq), 0, "resetReq after reset");

    curReq = "R2";
    drive(0, 1, 0, 5);
    settle();
    chk("R2", int'(countOut), 5, "five ticks");
    drive(0, 0, 0, 3);
    settle();
    chk("R2", int'(countOut), 5, "no tick holds");
    for (int i = 0; i < 2; i++) begin drive(0, 1, 0, 1); drive(0, 0, 0, 1); end
    settle();
    chk("R2", int'(countOut), 7, "sparse ticks");

    curReq = "R3";
    drive(1, 1, 0, 1);
    settle();
    chk("R3", int'(countOut), 0, "kick with tick");
    drive(0, 1, 0, 2);
    drive(1, 0, 0, 1);
    settle();
    chk("R3", int'(countOut), 0, "kick without tick");

    curReq = "R4";
    drive(0, 1, 0, H - 1);
    settle();
    chk("R4", int'(irqOut), 0, "irq low just before half");
    drive(0, 1, 0, 1);
    settle();
    chk("R4", int'(irqOut), 1, "irq at half");

    curReq = "R5";
    drive(0, 0, 0, 4);
    settle();
    chk("R5", int'(irqOut), 1, "irq holds");
    drive(0, 0, 1, 1);
    settle();
    chk("R5", int'(irqOut), 0, "irqClear drops irq");

    curReq = "R6";
    drive(0, 1, 0, P - H - 1);
    settle();
    chk("R6", int'(countOut), P - 1, "count at last");
    drive(0, 1, 0, 1);
    settle();
    chk("R6", int'(resetReq), 1, "reset pulse");
    chk("R6", int'(countOut), 0, "wrap to zero");
    settle();
    chk("R6", int'(resetReq), 0, "pulse one cycle");

    curReq = "R8";
    drive(0, 1, 0, P - 1);
    settle();
    chk("R8", int'(irqOut), 1, "irq left set before reset");
    drive(0, 1, 0, 1);
    settle();
    chk("R8", int'(irqOut), 0, "reset drops irq");

    curReq = "R7";
    drive(0, 1, 0, P - 1);
    drive(1, 1, 0, 1);
    settle();
    chk("R7", int'(resetReq), 0, "kick beats reset");
    chk("R7", int'(countOut), 0, "count zero after kick");

    curReq = "R5";
    drive(0, 1, 0, H - 1);
    drive(0, 1, 1, 1);
    settle();
    chk("R5", int'(irqOut), 1, "warning beats clear");
    drive(1, 0, 0, 1);
    settle();
    chk("R5", int'(irqOut), 0, "kick drops irq");

    settle();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule